// File: doc/BRIEF.md
# Byte-Stuffing Frame Encoder

This block turns a stream of payload bytes into a framed byte stream for a serial transmitter. A frame can open and close with a separator byte. Any payload byte that would be mistaken for a control character is replaced by a two-byte escape pair: a lead byte followed by a substitute byte. A 16-bit CCITT checksum of the payload can be placed after the last payload byte, and its two bytes go through the same escape logic.

Both the input and the output are valid/ready byte streams. The input also carries an end-of-packet flag.

- **Output back-pressure:** a byte is transferred only on a cycle where valid and ready are both high. While `out_ready` is low, the offered byte and its valid stay unchanged.
- **Input back-pressure:** the input is taken only when the output register can accept a new byte. The input is also held off for the whole cycle in which the second byte of an escape pair goes out, so no input byte is lost.
- **Configuration:** the control characters, substitute bytes and enables are plain inputs. They are expected to stay constant during a frame.

Top module: `esc_frame_enc`

## Requirements
- R1: With `cfg_sep_en`=1, each frame starts with `cfg_sep_char` and ends with `cfg_sep_char`. With `cfg_sep_en`=0, no separator is emitted.
- R2: With `cfg_esc_en[0]`=1, a payload byte equal to `cfg_sep_char` is sent as `cfg_esc_char` then `cfg_sub_sep`. With the bit clear, the byte is sent unchanged.
- R3: With `cfg_esc_en[1]`=1, a payload byte equal to `cfg_esc_char` is sent as `cfg_esc_char` then `cfg_sub_esc`. With the bit clear, the byte is sent unchanged.
- R4: The flow-control bytes are handled separately:
  - With `cfg_esc_en[2]`=1, 0x11 is sent as `cfg_esc_char` then `cfg_sub_xon`.
  - With `cfg_esc_en[3]`=1, 0x13 is sent as `cfg_esc_char` then `cfg_sub_xoff`.
  - With its bit clear, each of these bytes passes unchanged.
- R5: With `cfg_crc_en`=1, a CRC over the payload bytes is sent after the last payload byte and before the closing separator. The CRC uses polynomial 0x1021, initial value 0xFFFF, MSB-first bit order and no final inversion. The high byte goes first, and both bytes are escaped like payload bytes.
- R6: `in_ready` is low in the cycle where the second byte of an escape pair is emitted. Every input byte appears exactly once in the output, whatever the output back-pressure.
- R7: While `out_valid`=1 and `out_ready`=0, the next cycle still has `out_valid`=1 with the same `out_data`.
- R8: A pulse on `soft_rst` returns the encoder to idle, drops any byte being offered, and restarts the CRC for the next frame.
- R9: `enc_state` reports the encoder state with this encoding:

  | Value | State |
  |---|---|
  | 0 | idle |
  | 1 | start separator |
  | 2 | payload |
  | 3 | escape second byte |
  | 4 | CRC high |
  | 5 | CRC low |
  | 6 | end separator |

- R10: After `rst_n` is asserted, `out_valid`=0, `in_ready`=0 and `enc_state`=0.
- R11: The separator, lead and substitute characters come from the configuration inputs and are not fixed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous encoder reset |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the last payload byte of a frame |
| in_ready | output | 1 | Encoder takes the payload byte |
| out_valid | output | 1 | Encoded byte offered |
| out_data | output | 8 | Encoded byte |
| out_ready | input | 1 | Downstream takes the encoded byte |
| cfg_sep_en | input | 1 | Enable the opening and closing separator |
| cfg_crc_en | input | 1 | Enable the CRC trailer |
| cfg_esc_en | input | 4 | Escape enables: [0] separator, [1] lead char, [2] 0x11, [3] 0x13 |
| cfg_sep_char | input | 8 | Separator value |
| cfg_esc_char | input | 8 | Escape lead value |
| cfg_sub_sep | input | 8 | Substitute byte for the separator |
| cfg_sub_esc | input | 8 | Substitute byte for the lead char |
| cfg_sub_xon | input | 8 | Substitute byte for 0x11 |
| cfg_sub_xoff | input | 8 | Substitute byte for 0x13 |
| enc_state | output | 3 | Encoder state, encoded as in R9 |

## Verification
The hardest case to reach is an escape pair that is pending while the output is stalled, especially when the escaped byte is the last payload byte. In that case the substitute byte must still come out before the CRC and the separator. The stimulus table places escapable bytes at the ends of frames and throttles `out_ready` with periodic patterns, so escape pairs, CRC bytes and separators all meet back-pressure. A reference model in the bench builds the expected stream from the requirements, including escaping the CRC bytes, and compares it with the received stream byte by byte. Soft reset is tested by stalling the output right after the opening separator and pulsing `soft_rst` while a byte is still held.

// File: rtl/esc_frame_pkg.sv
package esc_frame_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SOP  = 3'd1,
    ST_PAY  = 3'd2,
    ST_ESC2 = 3'd3,
    ST_CRCH = 3'd4,
    ST_CRCL = 3'd5,
    ST_EOP  = 3'd6
  } enc_state_e;

  localparam int NUM_ESC = 4;
endpackage

// File: rtl/esc_frame_map.sv
// Decides whether a byte needs an escape pair and picks its substitute byte.
module esc_frame_map import esc_frame_pkg::*; #(
  parameter int DW = 8,
  parameter logic [DW-1:0] XON_CHAR  = 8'h11,
  parameter logic [DW-1:0] XOFF_CHAR = 8'h13
) (
  input  logic [DW-1:0]      byte_i,
  input  logic [NUM_ESC-1:0] esc_en,
  input  logic [DW-1:0]      sep_char,
  input  logic [DW-1:0]      esc_char,
  input  logic [DW-1:0]      sub_sep,
  input  logic [DW-1:0]      sub_esc,
  input  logic [DW-1:0]      sub_xon,
  input  logic [DW-1:0]      sub_xoff,
  output logic               hit,
  output logic [DW-1:0]      sub_o
);
  logic [DW-1:0]      key  [NUM_ESC];
  logic [DW-1:0]      subv [NUM_ESC];
  logic [NUM_ESC-1:0] match;

  assign key[0]  = sep_char;
  assign key[1]  = esc_char;
  assign key[2]  = XON_CHAR;
  assign key[3]  = XOFF_CHAR;

  assign subv[0] = sub_sep;
  assign subv[1] = sub_esc;
  assign subv[2] = sub_xon;
  assign subv[3] = sub_xoff;

  for (genvar k = 0; k < NUM_ESC; k++) begin : g_match
    assign match[k] = esc_en[k] && (byte_i == key[k]);
  end

  // Lowest index wins when programmed characters overlap.
  always_comb begin
    sub_o = '0;
    for (int k = NUM_ESC - 1; k >= 0; k--) begin
      if (match[k]) sub_o = subv[k];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/esc_frame_crc.sv
// One-byte CRC update, MSB first, no reflection.
module esc_frame_crc #(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY = 16'h1021
) (
  input  logic [CW-1:0] crc_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);
  always_comb begin
    logic fb;
    crc_o = crc_i;
    for (int i = DW - 1; i >= 0; i--) begin
      fb    = crc_o[CW-1] ^ data_i[i];
      crc_o = {crc_o[CW-2:0], 1'b0};
      if (fb) crc_o = crc_o ^ POLY;
    end
  end
endmodule

// File: rtl/esc_frame_enc.sv
module esc_frame_enc import esc_frame_pkg::*; #(
  parameter int DW = 8,
  parameter logic [2*DW-1:0] POLY      = 16'h1021,
  parameter logic [2*DW-1:0] CRC_INIT  = 16'hFFFF,
  parameter logic [DW-1:0]   XON_CHAR  = 8'h11,
  parameter logic [DW-1:0]   XOFF_CHAR = 8'h13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               in_valid,
  input  logic [DW-1:0]      in_data,
  input  logic               in_last,
  output logic               in_ready,
  output logic               out_valid,
  output logic [DW-1:0]      out_data,
  input  logic               out_ready,
  input  logic               cfg_sep_en,
  input  logic               cfg_crc_en,
  input  logic [NUM_ESC-1:0] cfg_esc_en,
  input  logic [DW-1:0]      cfg_sep_char,
  input  logic [DW-1:0]      cfg_esc_char,
  input  logic [DW-1:0]      cfg_sub_sep,
  input  logic [DW-1:0]      cfg_sub_esc,
  input  logic [DW-1:0]      cfg_sub_xon,
  input  logic [DW-1:0]      cfg_sub_xoff,
  output logic [2:0]         enc_state
);
  localparam int CW = 2 * DW;

  enc_state_e    st_q, st_d, ret_q, ret_d, nxt;
  logic [DW-1:0] od_q, od_d, sub_q, sub_d, src, sub_byte;
  logic          ov_q, ov_d, hit, adv;
  logic [CW-1:0] crc_q, crc_d, crc_nx;
  enc_state_e    after_pay, after_crc;

  // The output register can take a new byte this cycle.
  assign adv = !ov_q || out_ready;

  always_comb begin
    case (st_q)
      ST_CRCH: src = crc_q[CW-1:DW];
      ST_CRCL: src = crc_q[DW-1:0];
      default: src = in_data;
    endcase
  end

  esc_frame_map #(.DW(DW), .XON_CHAR(XON_CHAR), .XOFF_CHAR(XOFF_CHAR)) map_i (
    .byte_i(src), .esc_en(cfg_esc_en), .sep_char(cfg_sep_char), .esc_char(cfg_esc_char),
    .sub_sep(cfg_sub_sep), .sub_esc(cfg_sub_esc), .sub_xon(cfg_sub_xon),
    .sub_xoff(cfg_sub_xoff), .hit(hit), .sub_o(sub_byte)
  );

  esc_frame_crc #(.DW(DW), .CW(CW), .POLY(POLY)) crc_i (
    .crc_i(crc_q), .data_i(in_data), .crc_o(crc_nx)
  );

  assign after_crc = cfg_sep_en ? ST_EOP : ST_IDLE;
  assign after_pay = cfg_crc_en ? ST_CRCH : after_crc;

  always_comb begin
    st_d     = st_q;
    ret_d    = ret_q;
    od_d     = od_q;
    ov_d     = ov_q;
    sub_d    = sub_q;
    crc_d    = crc_q;
    in_ready = 1'b0;
    nxt      = st_q;
    if (adv) ov_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        crc_d = CRC_INIT;
        if (in_valid) st_d = cfg_sep_en ? ST_SOP : ST_PAY;
      end
      ST_SOP: if (adv) begin
        od_d = cfg_sep_char; ov_d = 1'b1; st_d = ST_PAY;
      end
      ST_PAY, ST_CRCH, ST_CRCL: begin
        if (st_q == ST_PAY) in_ready = adv;
        if (adv && (st_q != ST_PAY || in_valid)) begin
          case (st_q)
            ST_PAY:  begin nxt = in_last ? after_pay : ST_PAY; crc_d = crc_nx; end
            ST_CRCH: nxt = ST_CRCL;
            default: nxt = after_crc;
          endcase
          ov_d = 1'b1;
          if (hit) begin
            od_d = cfg_esc_char; sub_d = sub_byte; ret_d = nxt; st_d = ST_ESC2;
          end else begin
            od_d = src; st_d = nxt;
          end
        end
      end
      ST_ESC2: if (adv) begin
        od_d = sub_q; ov_d = 1'b1; st_d = ret_q;
      end
      ST_EOP: if (adv) begin
        od_d = cfg_sep_char; ov_d = 1'b1; st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ret_q <= ST_IDLE; od_q <= '0; ov_q <= 1'b0;
      sub_q <= '0; crc_q <= CRC_INIT;
    end else if (soft_rst) begin
      st_q <= ST_IDLE; ret_q <= ST_IDLE; ov_q <= 1'b0; crc_q <= CRC_INIT;
    end else begin
      st_q <= st_d; ret_q <= ret_d; od_q <= od_d; ov_q <= ov_d;
      sub_q <= sub_d; crc_q <= crc_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign enc_state = st_q;

  // R7: a stalled byte stays put.
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !soft_rst) |=> (out_valid && $stable(out_data)));

  // R6: no input accepted while the substitute byte is being issued.
  a_r6_stall_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_state == 3'd3) |-> !in_ready);

  // R8: soft reset forces idle and drops the offered byte.
  a_r8_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (enc_state == 3'd0 && !out_valid));

  // R1: the start-separator state produces the separator byte.
  a_r1_open_sep: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_state == 3'd1 && adv && !soft_rst) |=> (out_valid && out_data == $past(cfg_sep_char)));
endmodule

// File: tb/esc_frame_enc_tb_top.sv
module esc_frame_enc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid;
  logic [7:0] out_data;
  logic [2:0] enc_state;
  logic cfg_sep_en = 1'b1, cfg_crc_en = 1'b1;
  logic [3:0] cfg_esc_en = 4'hF;
  logic [7:0] cfg_sep_char = 8'hC0, cfg_esc_char = 8'hDB;
  logic [7:0] cfg_sub_sep = 8'hDC, cfg_sub_esc = 8'hDD, cfg_sub_xon = 8'hDE, cfg_sub_xoff = 8'hDF;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  esc_frame_enc dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .cfg_sep_en(cfg_sep_en), .cfg_crc_en(cfg_crc_en),
    .cfg_esc_en(cfg_esc_en), .cfg_sep_char(cfg_sep_char), .cfg_esc_char(cfg_esc_char),
    .cfg_sub_sep(cfg_sub_sep), .cfg_sub_esc(cfg_sub_esc), .cfg_sub_xon(cfg_sub_xon),
    .cfg_sub_xoff(cfg_sub_xoff), .enc_state(enc_state)
  );

  typedef struct packed {
    logic [2:0]  len;
    logic [31:0] pl;
    logic [3:0]  esc;
    logic        sep;
    logic        crc;
    logic [1:0]  bp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd1, 32'h41000000, 4'hF, 1'b1, 1'b1, 2'd0},
    '{3'd4, 32'hC0DB1113, 4'h3, 1'b1, 1'b0, 2'd1},
    '{3'd4, 32'hC0DB1113, 4'hF, 1'b1, 1'b1, 2'd2},
    '{3'd4, 32'hC0DB1113, 4'h0, 1'b0, 1'b0, 2'd0},
    '{3'd4, 32'h31323334, 4'hF, 1'b1, 1'b1, 2'd1},
    '{3'd2, 32'h11130000, 4'hC, 1'b0, 1'b1, 2'd2},
    '{3'd3, 32'hDBDBC000, 4'h3, 1'b1, 1'b0, 2'd1},
    '{3'd1, 32'h00000000, 4'hF, 1'b1, 1'b1, 2'd0}
  };

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic push_esc(input logic [7:0] b, input logic [3:0] en);
    if (en[0] && b == cfg_sep_char) begin exp_q.push_back(cfg_esc_char); exp_q.push_back(cfg_sub_sep); end
    else if (en[1] && b == cfg_esc_char) begin exp_q.push_back(cfg_esc_char); exp_q.push_back(cfg_sub_esc); end
    else if (en[2] && b == 8'h11) begin exp_q.push_back(cfg_esc_char); exp_q.push_back(cfg_sub_xon); end
    else if (en[3] && b == 8'h13) begin exp_q.push_back(cfg_esc_char); exp_q.push_back(cfg_sub_xoff); end
    else exp_q.push_back(b);
  endtask

  function automatic bit rdy(input logic [1:0] bp, input int cyc);
    case (bp)
      2'd0: return 1'b1;
      2'd1: return cyc[0];
      default: return (cyc % 3) == 0;
    endcase
  endfunction

  task automatic run_frame(input vec_t v, input int id);
    int idx = 0;
    int cyc = 0;
    logic [15:0] c = 16'hFFFF;
    bit stalled = 1'b0;
    logic [7:0] held = 8'h00;
    exp_q.delete(); got_q.delete();
    cfg_esc_en = v.esc; cfg_sep_en = v.sep; cfg_crc_en = v.crc;
    if (v.sep) exp_q.push_back(cfg_sep_char);
    for (int i = 0; i < v.len; i++) begin
      logic [7:0] b = v.pl[31-8*i -: 8];
      push_esc(b, v.esc);
      c = crc_byte(c, b);
    end
    if (v.crc) begin push_esc(c[15:8], v.esc); push_esc(c[7:0], v.esc); end
    if (v.sep) exp_q.push_back(cfg_sep_char);
    while (cyc < 400) begin
      @(negedge clk);
      out_ready = rdy(v.bp, cyc);
      in_valid  = (idx < v.len);
      in_data   = (idx < v.len) ? v.pl[31-8*idx -: 8] : 8'h00;
      in_last   = (idx == v.len - 1);
      #1;
      if (stalled) chk(out_valid && out_data == held, "R7 hold", out_data, held);
      if (enc_state == 3'd3) chk(!in_ready, "R6 stall on pair", in_ready, 0);
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) got_q.push_back(out_data);
      stalled = out_valid && !out_ready;
      held = out_data;
      cyc++;
      if (idx == v.len && got_q.size() >= exp_q.size() && enc_state == 3'd0 && !out_valid) break;
    end
    in_valid = 1'b0; in_last = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); out_ready = 1'b1; #1;
      if (out_valid) got_q.push_back(out_data);
    end
    chk(got_q.size() == exp_q.size(), $sformatf("R1 R5 R6 frame %0d length", id), got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], $sformatf("R1 R2 R3 R4 R5 frame %0d byte %0d", id, i), got_q[i], exp_q[i]);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R10 out_valid", out_valid, 0);
    chk(!in_ready, "R10 in_ready", in_ready, 0);
    chk(enc_state == 3'd0, "R10 state", enc_state, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int n = 0; n < 8; n++) run_frame(VECS[n], n);

    // R8/R9: stall after the opening separator, then soft reset.
    cfg_sep_en = 1'b1; cfg_crc_en = 1'b1; cfg_esc_en = 4'hF;
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h41; in_last = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(enc_state == 3'd2, "R9 payload state", enc_state, 2);
    chk(out_valid && out_data == 8'hC0, "R1 R7 held separator", out_data, 8'hC0);
    in_valid = 1'b0; soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0; #1;
    chk(enc_state == 3'd0, "R8 idle after soft reset", enc_state, 0);
    chk(!out_valid, "R8 offered byte dropped", out_valid, 0);
    run_frame(VECS[0], 20);

    // R11: other control characters.
    cfg_sep_char = 8'h7E; cfg_esc_char = 8'h7D; cfg_sub_sep = 8'h5E; cfg_sub_esc = 8'h5D;
    cfg_sub_xon = 8'h31; cfg_sub_xoff = 8'h33;
    run_frame('{3'd4, 32'h7E7DC011, 4'hF, 1'b1, 1'b1, 2'd1}, 30);
    run_frame('{3'd2, 32'h137E0000, 4'hF, 1'b0, 1'b1, 2'd2}, 31);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule